// File: doc/BRIEF.md
# Broadcast-Input Convolution Accumulator Array

This block computes a one-dimensional convolution of a sample stream with a short kernel of K signed weights. Every accepted input sample goes to all K cells in the same cycle over a common broadcast bus, so each sample fetched from the stream feeds K multiplications. The weights sit in a ring of registers that rotates one hop per accepted sample. Each cell therefore meets every kernel tap in turn. A result is pinned to one cell and grows in that cell's wide accumulator until it holds all K terms. It is then handed to a shared collection bus and registered at the output.

Kernel taps are loaded in natural order through a weight port. A load also restarts the result index, so results of the old kernel are never mixed with results of the new one. With kernel w_0..w_{K-1} and samples x_0, x_1, ..., result m equals the sum over j of w_j * x_{m+j}. The results come out in index order, one per sample once the array has filled, and each one appears one cycle after the sample that completes it.

Top module: `bcast_conv_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `out_valid` is 0 and `out_y` is 0.
- R2: Each cycle with `wt_valid` high takes `wt_w` as the next kernel tap. Exactly K such cycles in a row load w_0 first and w_{K-1} last. A sample presented in a cycle where `wt_valid` is high is ignored.
- R3: Each output equals the exact signed sum over j=0..K-1 of w_j * x_{m+j}, where m is the output's index counted from the first sample after the last weight load.
- R4: A stream of n samples after a load yields exactly n+1-K outputs, or none when n < K. They come in increasing index order: the first follows the K-th sample and each later sample yields one more.
- R5: `out_valid` is high in the cycle right after the `in_valid` cycle that completes a result, and it stays high for that one cycle only.
- R6: Cycles without `in_valid` produce no output and do not change later results. Idle gaps of any length between samples give the same values as a gapless stream.
- R7: The accumulator is XW+WW+clog2(K) bits wide and signed, so a full sum of extreme products (for example K * (-128) * (-128) = 65536 at the defaults) comes out exact without wrapping.
- R8: At most one cell completes a result in any cycle.
- R9: A cell that hands off a result starts its next result on the following sample with no lost cycle, so back-to-back samples give back-to-back outputs.
- R10: A weight load discards every partial result. After a load, no output appears until K new samples have been accepted.
- R11: While `out_valid` is low, `out_y` holds the last result it carried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wt_valid | input | 1 | Load the next kernel tap |
| wt_w | input | WW | Kernel tap value, signed |
| in_valid | input | 1 | Input sample present |
| in_x | input | XW | Input sample, signed |
| out_valid | output | 1 | Result present on out_y |
| out_y | output | XW+WW+clog2(K) | Convolution result, signed |

## Verification
An asymmetric kernel driven with a gapless random stream shows whether the taps are applied in the right order and whether results leave the array back to back. The same kind of stream with random idle gaps separates per-sample stepping from per-cycle stepping. Constant extreme operands fill the accumulator to its positive and negative limits, which exposes any truncation. Reloading the kernel after fewer than K samples shows whether partial sums and the index are really discarded, and every stream also checks the output count and the cycle in which each result appears.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // Width of a result register that can hold a K-term sum of XW x WW products
  function automatic int acc_width(input int xw, input int ww, input int k);
    return xw + ww + $clog2(k);
  endfunction

  // Width of a counter that must reach k-1
  function automatic int idx_width(input int k);
    return (k > 1) ? $clog2(k) : 1;
  endfunction

endpackage

// File: rtl/weight_ring.sv
module weight_ring #(
  parameter int WW = 8,
  parameter int K  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [WW-1:0]   load_w,
  input  logic                   step,
  output logic [K-1:0][WW-1:0]   tap_in
);

  logic [K-1:0][WW-1:0] ring_q;

  // Cell 0 takes a new tap on load and the wrapped tap on rotation
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
    end else if (load) begin
      ring_q[0] <= load_w;
      for (int c = 1; c < K; c++) ring_q[c] <= ring_q[c-1];
    end else if (step) begin
      ring_q[0] <= ring_q[K-1];
      for (int c = 1; c < K; c++) ring_q[c] <= ring_q[c-1];
    end
  end

  // Each cell multiplies with the tap arriving at it this hop
  generate
    for (genvar c = 0; c < K; c++) begin : g_tap
      if (c == 0) begin : g_wrap
        assign tap_in[c] = ring_q[K-1];
      end else begin : g_chain
        assign tap_in[c] = ring_q[c-1];
      end
    end
  endgenerate

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  output logic [K-1:0] start_oh,
  output logic [K-1:0] done_oh
);

  localparam int CW = conv_pkg::idx_width(K);
  localparam logic [CW-1:0] FULL = CW'(K - 1);

  logic [K-1:0]  owner_q;
  logic [CW-1:0] fill_q;
  logic [K-1:0]  next_owner;
  logic          primed;

  // The cell after the starting one owns the result that ends now
  generate
    if (K == 1) begin : g_single
      assign next_owner = owner_q;
    end else begin : g_multi
      assign next_owner = {owner_q[K-2:0], owner_q[K-1]};
    end
  endgenerate

  assign primed   = (fill_q == FULL);
  assign start_oh = step ? owner_q : '0;
  assign done_oh  = (step && primed) ? next_owner : '0;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      owner_q <= K'(1);
      fill_q  <= '0;
    end else if (step) begin
      owner_q <= next_owner;
      if (!primed) fill_q <= fill_q + CW'(1);
    end
  end

endmodule

// File: rtl/mac_cell.sv
module mac_cell #(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int AW = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  en,
  input  logic                  start,
  input  logic                  done,
  input  logic signed [XW-1:0]  x,
  input  logic signed [WW-1:0]  w,
  output logic signed [AW-1:0]  sum
);

  logic signed [XW+WW-1:0] prod;
  logic signed [AW-1:0]    prod_ext;
  logic signed [AW-1:0]    base;
  logic signed [AW-1:0]    acc_q;

  assign prod     = x * w;
  assign prod_ext = AW'(prod);
  assign base     = start ? '0 : acc_q;
  assign sum      = base + prod_ext;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= done ? '0 : sum;
    end
  end

endmodule

// File: rtl/out_collect.sv
module out_collect #(
  parameter int AW = 18,
  parameter int K  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [K-1:0]         sel_oh,
  input  logic [K-1:0][AW-1:0] cell_sum,
  output logic                 out_valid,
  output logic [AW-1:0]        out_y
);

  logic [AW-1:0] bus_y;

  // Shared collection bus: the one selected cell drives it
  always_comb begin
    bus_y = '0;
    for (int c = 0; c < K; c++) begin
      if (sel_oh[c]) bus_y = bus_y | cell_sum[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= |sel_oh;
      if (|sel_oh) out_y <= bus_y;
    end
  end

endmodule

// File: rtl/bcast_conv_array.sv
module bcast_conv_array #(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int K  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wt_valid,
  input  logic [WW-1:0]                 wt_w,
  input  logic                          in_valid,
  input  logic [XW-1:0]                 in_x,
  output logic                          out_valid,
  output logic [XW+WW+$clog2(K)-1:0]    out_y
);

  localparam int AW = conv_pkg::acc_width(XW, WW, K);

  logic                 step;
  logic [K-1:0][WW-1:0] tap_in;
  logic [K-1:0]         start_oh;
  logic [K-1:0]         done_oh;
  logic [K-1:0][AW-1:0] cell_sum;

  // A load takes priority; a sample in the same cycle is dropped
  assign step = in_valid && !wt_valid;

  weight_ring #(.WW(WW), .K(K)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .load   (wt_valid),
    .load_w ($signed(wt_w)),
    .step   (step),
    .tap_in (tap_in)
  );

  phase_ctrl #(.K(K)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .restart  (wt_valid),
    .step     (step),
    .start_oh (start_oh),
    .done_oh  (done_oh)
  );

  generate
    for (genvar c = 0; c < K; c++) begin : g_cell
      logic signed [AW-1:0] sum_c;
      mac_cell #(.XW(XW), .WW(WW), .AW(AW)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .clear (wt_valid),
        .en    (step),
        .start (start_oh[c]),
        .done  (done_oh[c]),
        .x     ($signed(in_x)),
        .w     ($signed(tap_in[c])),
        .sum   (sum_c)
      );
      assign cell_sum[c] = sum_c;
    end
  endgenerate

  out_collect #(.AW(AW), .K(K)) u_out (
    .clk       (clk),
    .rst       (rst),
    .sel_oh    (done_oh),
    .cell_sum  (cell_sum),
    .out_valid (out_valid),
    .out_y     (out_y)
  );

endmodule

// File: rtl/bcast_conv_array_chk.sv
module bcast_conv_array_chk #(
  parameter int K  = 4,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          wt_valid,
  input logic          in_valid,
  input logic          out_valid,
  input logic [AW-1:0] out_y,
  input logic [K-1:0]  done_oh
);

  localparam int NW = $clog2(K + 1);
  localparam logic [NW-1:0] LAST = NW'(K - 1);
  localparam logic [NW-1:0] CAP  = NW'(K);

  logic [NW-1:0] seen_q;

  // Samples accepted since the last load, saturating at K
  always_ff @(posedge clk) begin
    if (rst || wt_valid) seen_q <= '0;
    else if (in_valid && seen_q < CAP) seen_q <= seen_q + NW'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == '0));

  assert_load_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    wt_valid |=> !out_valid);

  assert_filled_emits_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wt_valid && seen_q >= LAST) |=> out_valid);

  assert_idle_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_one_owner_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_oh));

  assert_unfilled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wt_valid && seen_q < LAST) |=> !out_valid);

  assert_hold_value_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_y));

endmodule

bind bcast_conv_array bcast_conv_array_chk #(.K(K), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wt_valid  (wt_valid),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_y     (out_y),
  .done_oh   (done_oh)
);

// File: tb/bcast_conv_array_test.sv
module bcast_conv_array_test;

  localparam int XW = 8;
  localparam int WW = 8;
  localparam int K  = 4;
  localparam int AW = XW + WW + $clog2(K);

  typedef struct {
    longint val;
    int     cyc;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wt_valid = 1'b0;
  logic [WW-1:0] wt_w = '0;
  logic          in_valid = 1'b0;
  logic [XW-1:0] in_x = '0;
  logic          out_valid;
  logic [AW-1:0] out_y;

  int     checks = 0;
  int     fails = 0;
  int     cyc = 0;
  int     rx_count = 0;
  int     kern[K];
  int     xs[$];
  exp_t   q[$];
  logic [AW-1:0] last_y = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcast_conv_array #(.XW(XW), .WW(WW), .K(K)) uut (
    .clk(clk), .rst(rst), .wt_valid(wt_valid), .wt_w(wt_w),
    .in_valid(in_valid), .in_x(in_x), .out_valid(out_valid), .out_y(out_y)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        rx_count++;
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected output", longint'($signed(out_y)), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(longint'($signed(out_y)) == e.val, "R3 value", longint'($signed(out_y)), e.val);
          check(cyc == e.cyc, "R5 timing", cyc, e.cyc);
        end
        last_y = out_y;
      end else begin
        check(out_y == last_y, "R11 hold", longint'($signed(out_y)), longint'($signed(last_y)));
        if (q.size() > 0 && q[0].cyc < cyc)
          check(1'b0, "R4 missing output", 0, q[0].val);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      wt_valid = 1'b0;
    end
  endtask

  // R2: taps loaded in natural order, kernel history restarts
  task automatic load_kernel(input int w0, input int w1, input int w2, input int w3);
    kern[0] = w0; kern[1] = w1; kern[2] = w2; kern[3] = w3;
    for (int k = 0; k < K; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      wt_valid = 1'b1;
      wt_w = WW'(kern[k]);
    end
    xs.delete();
    idle(1);
  endtask

  // Driver: pushes the expected sliding-window dot product
  task automatic send(input int x);
    @(negedge clk);
    wt_valid = 1'b0;
    in_valid = 1'b1;
    in_x = XW'(x);
    xs.push_back(x);
    if (xs.size() >= K) begin
      exp_t e;
      int m;
      m = xs.size() - K;
      e.val = 0;
      for (int j = 0; j < K; j++) e.val += longint'(kern[j]) * longint'(xs[m + j]);
      e.cyc = cyc + 1;
      q.push_back(e);
    end
  endtask

  task automatic finish_phase(input int n, input int rx0, input string req);
    int want;
    idle(K + 3);
    want = (n >= K) ? n + 1 - K : 0;
    check(rx_count - rx0 == want, req, rx_count - rx0, want);
    check(q.size() == 0, "R4 drained", q.size(), 0);
  endtask

  function automatic int rnd8();
    return int'($signed(8'($urandom)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rx0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_y == '0, "R1 reset data", longint'(out_y), 0);
    rst = 1'b0;
    idle(2);

    // R2 R3 R9: asymmetric kernel, gapless stream
    load_kernel(3, -5, 7, -2);
    rx0 = rx_count;
    for (int i = 0; i < 20; i++) send(rnd8());
    finish_phase(20, rx0, "R4 count gapless");

    // R6: random kernel, random idle gaps
    load_kernel(rnd8(), rnd8(), rnd8(), rnd8());
    rx0 = rx_count;
    for (int i = 0; i < 25; i++) begin
      send(rnd8());
      idle(int'($urandom_range(0, 3)));
    end
    finish_phase(25, rx0, "R6 count with gaps");

    // R7: extreme positive sum
    load_kernel(-128, -128, -128, -128);
    rx0 = rx_count;
    for (int i = 0; i < 6; i++) send(-128);
    finish_phase(6, rx0, "R7 count max");

    // R7: extreme negative sum
    load_kernel(127, 127, 127, 127);
    rx0 = rx_count;
    for (int i = 0; i < 6; i++) send(-128);
    finish_phase(6, rx0, "R7 count min");

    // R10: partial stream discarded by a reload
    load_kernel(1, 2, 3, 4);
    rx0 = rx_count;
    send(50); send(-60);
    load_kernel(-7, 11, -13, 17);
    for (int i = 0; i < 10; i++) send(rnd8());
    finish_phase(10, rx0, "R10 count after reload");

    // R2: a sample coinciding with a tap load is ignored
    load_kernel(2, 0, 0, 0);
    rx0 = rx_count;
    @(negedge clk);
    wt_valid = 1'b1; in_valid = 1'b1; wt_w = WW'(5); in_x = XW'(99);
    kern[0] = 0; kern[1] = 0; kern[2] = 0; kern[3] = 5;
    @(negedge clk);
    wt_valid = 1'b0; in_valid = 1'b0;
    load_kernel(4, -3, 2, -1);
    for (int i = 0; i < 8; i++) send(rnd8());
    finish_phase(8, rx0, "R2 load beats sample");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule